// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers six interrupt sources into sticky request flags and decides, each cycle, whether the CPU core should be interrupted and where it should branch. The sources are: a supply-drop monitor (a level input), two external pin sources and three timer sources. The pin and timer sources arrive as single-cycle pulses. Every source has an individual enable bit. A single global enable flag gates all of them. When a request is raised, the block presents the highest-priority enabled pending source as a page number and a word address.

Each enable bit also chooses how its source is serviced. With the bit set, the source raises vectored interrupts. With the bit clear, the core can poll the flag with a test-and-skip operation. A poll that finds the flag set reports a skip and consumes the flag. Accepting an interrupt clears the chosen flag and the global enable, so handlers do not nest until the core re-enables interrupts. The supply-drop flag is special: it cannot be cleared while the supply-drop level is still present.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, all flags, all enable bits and the global enable are 0, so `irq_req` and `skip_take` are 0.
- R2: A source event sets its flag at the next clock edge whatever the state of the enables. The flag stays set until it is cleared by an acknowledge or by a successful skip.
- R3: `irq_req` is 1 exactly when the global enable is 1 and at least one source has both its flag and its enable bit at 1.
- R4: Source indices are 0 = supply drop, 1 = external 0, 2 = external 1, 3 = timer 1, 4 = timer 2, 5 = timer 3. Priority falls from index 0 to index 5, and the vector always names the lowest-indexed enabled pending source.
- R5: `vec_page` is 1. `vec_addr` is 0xE for supply drop, 0x0 for external 0, 0x2 for external 1, 0x4 for timer 1, 0x6 for timer 2 and 0x8 for timer 3.
- R6: When `irq_ack` is high while `irq_req` is high, the next edge clears the selected flag and the global enable. When `irq_ack` is high while `irq_req` is low, the acknowledge has no effect.
- R7: `gie_set` sets the global enable and `gie_clr` clears it. If both strobes are high in the same cycle, or a clear comes from an acknowledge, the clear wins.
- R8: `skip_take` is 1 when `skip_req` is 1, the source named by `skip_idx` has its flag at 1 and its enable bit at 0. In that case the flag is cleared at the next edge. When the enable bit is 1, the poll never skips.
- R9: While `vdrop_lvl` is 1, the supply-drop flag is 1 after every edge, even when an acknowledge or a skip targets it.
- R10: When a source event and a clear hit the same flag in the same cycle, the flag is set after the edge.
- R11: `cfg_wr_lo` loads bits 0..3 of `cfg_wdata` into the enables of indices 1..4. `cfg_wr_hi` loads bit 0 into the enable of index 5 and bit 3 into the enable of index 0. Bits 1 and 2 of a high write are ignored.
- R12: A `skip_idx` of 6 or 7 never skips and clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_pulse | input | 5 | Event pulses for indices 1..5 (bit 0 is index 1) |
| vdrop_lvl | input | 1 | Supply-drop condition level (index 0) |
| gie_set | input | 1 | Enable-interrupts strobe |
| gie_clr | input | 1 | Disable-interrupts strobe |
| cfg_wr_lo | input | 1 | Write the low enable register |
| cfg_wr_hi | input | 1 | Write the high enable register |
| cfg_wdata | input | 4 | Enable register write data |
| skip_req | input | 1 | Test-and-skip request |
| skip_idx | input | 3 | Source index to test |
| irq_ack | input | 1 | Interrupt accept pulse from the core |
| irq_req | output | 1 | Interrupt request to the core |
| vec_page | output | 4 | Vector page |
| vec_addr | output | 4 | Vector address within the page |
| skip_take | output | 1 | The tested flag was set and polling is allowed; skip next instruction |

## Verification
The bench targets these corner cases:
- Several flags pending at the moment the global enable returns. A wrong priority encoder would branch to a lower source.
- An acknowledge or a skip aimed at the supply-drop flag while its level is held. A design without the hold would lose the request.
- A pulse that coincides with the clear of the same flag. If the clear won, an event would be dropped.
- A skip poll on an enabled source, and a poll with an out-of-range index. A faulty design would consume a flag that only the interrupt path may clear.
- Writes that set the two reserved bits of the high register, and an acknowledge with no request pending. Either must leave the enables, the flags and the global enable untouched.

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int ADDR_W   = 4,
  parameter int PAGE_W   = 4,
  parameter int VEC_PAGE = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        evt_pulse,
  input  logic              vdrop_lvl,
  input  logic              gie_set,
  input  logic              gie_clr,
  input  logic              cfg_wr_lo,
  input  logic              cfg_wr_hi,
  input  logic [3:0]        cfg_wdata,
  input  logic              skip_req,
  input  logic [2:0]        skip_idx,
  input  logic              irq_ack,
  output logic              irq_req,
  output logic [PAGE_W-1:0] vec_page,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              skip_take
);
  localparam int NSRC = 6;
  localparam int SEL_W = $clog2(NSRC);

  logic [NSRC-1:0]  flag_q, en_q, set_v, clr_v, ready_v, skip_oh, skip_hit, ack_oh;
  logic             gie_q, take;
  logic [SEL_W-1:0] sel;

  function automatic logic [ADDR_W-1:0] vec_of(input logic [SEL_W-1:0] i);
    case (i)
      3'd0:    vec_of = ADDR_W'(4'hE);
      default: vec_of = ADDR_W'((i - 3'd1) * 2);
    endcase
  endfunction

  assign set_v   = {evt_pulse, vdrop_lvl};
  assign ready_v = flag_q & en_q;
  assign irq_req = gie_q & (|ready_v);
  assign take    = irq_ack & irq_req;

  always_comb begin
    sel = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (ready_v[i]) sel = SEL_W'(i);
  end

  assign vec_page = PAGE_W'(VEC_PAGE);
  assign vec_addr = vec_of(sel);

  assign skip_oh   = skip_req ? (NSRC'(1) << skip_idx) : '0;
  assign skip_hit  = skip_oh & flag_q & ~en_q;
  assign skip_take = |skip_hit;
  assign ack_oh    = take ? (NSRC'(1) << sel) : '0;
  assign clr_v     = skip_hit | ack_oh;

  for (genvar g = 0; g < NSRC; g++) begin : g_flag
    always_ff @(posedge clk)
      if (!rst_n) flag_q[g] <= 1'b0;
      else        flag_q[g] <= set_v[g] | (flag_q[g] & ~clr_v[g]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie_q <= 1'b0;
      en_q  <= '0;
    end else begin
      if (gie_clr || take) gie_q <= 1'b0;
      else if (gie_set)    gie_q <= 1'b1;
      if (cfg_wr_lo) en_q[4:1] <= cfg_wdata;
      if (cfg_wr_hi) begin
        en_q[5] <= cfg_wdata[0];
        en_q[0] <= cfg_wdata[3];
      end
    end
  end
endmodule

module irq_vector_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       vdrop_lvl,
  input logic       gie_clr,
  input logic       irq_ack,
  input logic       irq_req,
  input logic [3:0] vec_addr,
  input logic       skip_req,
  input logic       skip_take,
  input logic [5:0] flag_q,
  input logic [5:0] en_q,
  input logic       gie_q
);
  assert_req_needs_gie_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> gie_q);
  assert_ack_drops_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req) |=> !irq_req);
  assert_gie_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    gie_clr |=> !gie_q);
  assert_vdrop_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vdrop_lvl |=> flag_q[0]);
  assert_skip_needs_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    skip_take |-> skip_req);
  assert_top_vector_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && flag_q[0] && en_q[0]) |-> vec_addr == 4'hE);
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .vdrop_lvl(vdrop_lvl), .gie_clr(gie_clr),
  .irq_ack(irq_ack), .irq_req(irq_req), .vec_addr(vec_addr),
  .skip_req(skip_req), .skip_take(skip_take),
  .flag_q(flag_q), .en_q(en_q), .gie_q(gie_q)
);

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;
  logic clk = 0, rst_n = 0;
  logic [4:0] evt_pulse = 0;
  logic vdrop_lvl = 0, gie_set = 0, gie_clr = 0, cfg_wr_lo = 0, cfg_wr_hi = 0;
  logic [3:0] cfg_wdata = 0;
  logic skip_req = 0, irq_ack = 0;
  logic [2:0] skip_idx = 0;
  logic irq_req, skip_take;
  logic [3:0] vec_page, vec_addr;

  int n_chk = 0, n_bad = 0;
  logic [5:0] m_flag = 0, m_en = 0;
  logic m_gie = 0;

  always #2 clk = ~clk;

  irq_vector_ctrl u_irq_vector_ctrl (.*);

  function automatic int m_sel();
    for (int i = 0; i < 6; i++) if (m_flag[i] && m_en[i]) return i;
    return 0;
  endfunction
  function automatic logic m_req();
    return m_gie && |(m_flag & m_en);
  endfunction
  function automatic logic [3:0] m_vec(int i);
    logic [3:0] t[6] = '{4'hE, 4'h0, 4'h2, 4'h4, 4'h6, 4'h8};
    return t[i];
  endfunction
  function automatic logic m_skip();
    return skip_req && skip_idx < 6 && m_flag[skip_idx] && !m_en[skip_idx];
  endfunction

  task automatic check(string tag, string what, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(string tag);
    logic take, sk;
    logic [5:0] clr, set;
    int s;
    #1;
    check(tag, "irq_req", {3'b0, irq_req}, {3'b0, m_req()});
    check(tag, "skip_take", {3'b0, skip_take}, {3'b0, m_skip()});
    if (m_req()) begin
      check(tag, "vec_addr", vec_addr, m_vec(m_sel()));
      check(tag, "vec_page", vec_page, 4'h1);
    end
    take = irq_ack && m_req();
    sk = m_skip();
    s = m_sel();
    clr = 0;
    if (take) clr[s] = 1;
    if (sk) clr[skip_idx] = 1;
    set = {evt_pulse, vdrop_lvl};
    m_flag = set | (m_flag & ~clr);
    if (gie_clr || take) m_gie = 0; else if (gie_set) m_gie = 1;
    if (cfg_wr_lo) m_en[4:1] = cfg_wdata;
    if (cfg_wr_hi) begin m_en[5] = cfg_wdata[0]; m_en[0] = cfg_wdata[3]; end
    @(negedge clk);
    evt_pulse = 0; gie_set = 0; gie_clr = 0; cfg_wr_lo = 0; cfg_wr_hi = 0;
    skip_req = 0; irq_ack = 0;
  endtask

  initial begin
    #(4 * 150000);
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    cyc("R1");
    // R2: events with everything disabled, then poll them
    evt_pulse = 5'b11111; cyc("R2");
    cyc("R2");
    skip_req = 1; skip_idx = 3; cyc("R2 R8");
    skip_req = 1; skip_idx = 3; cyc("R8");
    skip_req = 1; skip_idx = 6; cyc("R12");
    skip_req = 1; skip_idx = 7; cyc("R12");
    // R11: reserved bits of high write ignored
    cfg_wr_hi = 1; cfg_wdata = 4'b0110; cyc("R11");
    gie_set = 1; cyc("R11 R7");
    cyc("R11 R3");
    // enable all, priority walk
    cfg_wr_lo = 1; cfg_wdata = 4'hF; cyc("R11");
    cfg_wr_hi = 1; cfg_wdata = 4'h9; cyc("R11");
    skip_req = 1; skip_idx = 1; cyc("R8");
    for (int k = 0; k < 6; k++) begin
      irq_ack = 1; cyc("R4 R5 R6");
      gie_set = 1; cyc("R6 R7");
    end
    // R7: simultaneous strobes
    gie_set = 1; gie_clr = 1; cyc("R7");
    evt_pulse = 5'b00001; cyc("R7");
    irq_ack = 1; cyc("R6");
    // R9: supply drop held
    vdrop_lvl = 1; gie_set = 1; cyc("R9");
    irq_ack = 1; cyc("R9");
    gie_set = 1; cyc("R9");
    cyc("R9");
    cfg_wr_hi = 1; cfg_wdata = 4'h0; cyc("R9");
    skip_req = 1; skip_idx = 0; cyc("R9 R8");
    vdrop_lvl = 0; skip_req = 1; skip_idx = 0; cyc("R9");
    skip_req = 1; skip_idx = 0; cyc("R9");
    // R10: coincident set and clear
    evt_pulse = 5'b00010; cyc("R10");
    skip_req = 1; skip_idx = 2; cfg_wr_lo = 1; cfg_wdata = 4'h0; cyc("R10");
    skip_req = 1; skip_idx = 2; evt_pulse = 5'b00010; cyc("R10");
    skip_req = 1; skip_idx = 2; cyc("R10");
    // random phase
    for (int n = 0; n < 4000; n++) begin
      evt_pulse[0] = ($urandom % 10) == 0;
      evt_pulse[1] = ($urandom % 10) == 0;
      evt_pulse[2] = ($urandom % 10) == 0;
      evt_pulse[3] = ($urandom % 10) == 0;
      evt_pulse[4] = ($urandom % 10) == 0;
      if (($urandom % 25) == 0) vdrop_lvl = ~vdrop_lvl;
      gie_set = ($urandom % 8) == 0;
      gie_clr = ($urandom % 20) == 0;
      cfg_wr_lo = ($urandom % 20) == 0;
      cfg_wr_hi = ($urandom % 20) == 0;
      cfg_wdata = 4'($urandom);
      skip_req = ($urandom % 4) == 0;
      skip_idx = 3'($urandom);
      irq_ack = ($urandom % 3) == 0;
      cyc("R2 R3 R4 R5 R6 R8 R10");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule